// File: doc/BRIEF.md
# Receive Buffer with Fill-Driven Request-to-Send

This block sits between the deserialiser of one asynchronous serial channel and the host bus. Each character that the receiver completes enters the block together with three error tags: parity, framing and break. The block stores the character with its tags and presents the oldest one at its output until the host reads it. Out of reset the block keeps just one character, as a simple holding register. When the host sets the buffer-enable input, it queues up to sixteen characters in arrival order.

While buffering is on, the block can also drive the request-to-send line by itself. The line is active low. Once the number of stored characters reaches a selectable trigger level, the block drives the line high, which tells the far end to stop sending. The line goes low again only when the host has drained the buffer, so the host never has to manage it. A separate active-low receive-ready output gives a DMA engine the same level-based indication. A flush empties the buffer in one cycle. A character that arrives when no room is left is dropped and raises a sticky overrun flag.

Top module: `rxfifo_autorts`

## Requirements
- R1: With buffer mode on, up to 16 characters are held and read out in arrival order. Each character comes out with its own error tags on `rd_err`: bit 0 is parity, bit 1 is framing and bit 2 is break.
- R2: After reset the outputs are `empty`=1, `data_ready`=0, `rxrdy_n`=1, `rts_n`=0 and `overrun`=0. Buffer mode is off unless `fifo_en` is driven high.
- R3: With `fifo_en`=0 the block holds one character. A write while that character is still unread is dropped, `overrun` is set and the held character stays at the output.
- R4: With buffer mode on and 16 characters stored, a write without a read in the same cycle is dropped and sets `overrun`. The stored characters and their order do not change.
- R5: A write and a read in the same cycle while the buffer is full both take effect: the head advances, the new character is stored and `overrun` stays clear. A read while the buffer is empty has no effect.
- R6: `trig_sel` selects the trigger level: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14. With `fifo_en`=1 and `autorts_en`=1, `rts_n` goes high at the clock edge where the stored count reaches the trigger level. It stays high until the buffer becomes empty.
- R7: `rts_n` is low whenever `fifo_en` or `autorts_en` is low.
- R8: With `fifo_en`=0, `rxrdy_n` is low exactly while a character is held. With `fifo_en`=1, `rxrdy_n` goes low when the count reaches the trigger level and returns high when the buffer is empty.
- R9: A flush empties the buffer and clears `overrun` at the next edge. A write in the same cycle as a flush is dropped. The mode inputs keep their effect: after a refill to the trigger level, `rts_n` rises again.
- R10: Any change of `fifo_en` empties the buffer and clears `overrun` at the next edge. A write in that cycle is dropped.
- R11: `data_ready` is the inverse of `empty`. `rd_data` and `rd_err` read as zero while the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Receiver strobe: store one character |
| wr_data | input | 8 | Received character |
| wr_err | input | 3 | Error tags of the character: bit 0 parity, bit 1 framing, bit 2 break |
| rd_en | input | 1 | Host strobe: remove the head character |
| fifo_en | input | 1 | 1 = 16-entry buffer mode, 0 = single holding register |
| autorts_en | input | 1 | Enable automatic request-to-send control |
| trig_sel | input | 2 | Trigger level select: 1, 4, 8 or 14 |
| flush | input | 1 | Empty the buffer and clear the overrun flag |
| rd_data | output | 8 | Head character, zero when empty |
| rd_err | output | 3 | Error tags of the head character, zero when empty |
| empty | output | 1 | No character stored |
| data_ready | output | 1 | At least one character stored |
| rxrdy_n | output | 1 | Active-low receive-ready indication for DMA |
| rts_n | output | 1 | Active-low request-to-send |
| overrun | output | 1 | Sticky flag: a character was dropped for lack of room |

## Verification
Three same-cycle collisions matter here: a receiver write against a host read while the buffer is full, a write against a flush, and a write against a change of buffer mode. The bench fills the buffer to sixteen characters and then drives write and read in the same cycle. It judges the result by draining the buffer: the old head must be gone, the new character must come out last, and the overrun flag must stay clear. For the flush and the mode change, the bench writes a marker character in the same cycle. It then checks that the buffer is empty and that the first character written afterwards, not the marker, appears at the head.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int ERR_W   = 3;
  localparam int ERR_PAR = 0;
  localparam int ERR_FRM = 1;
  localparam int ERR_BRK = 2;

  typedef enum logic [1:0] {
    TRIG_ONE  = 2'd0,
    TRIG_QTR  = 2'd1,
    TRIG_HALF = 2'd2,
    TRIG_NEAR = 2'd3
  } trig_sel_e;

  // Trigger level in entries for a buffer of the given depth.
  function automatic int unsigned trig_level(input logic [1:0] sel,
                                             input int unsigned depth);
    case (sel)
      TRIG_ONE:  return 1;
      TRIG_QTR:  return depth / 4;
      TRIG_HALF: return depth / 2;
      default:   return depth - 2;
    endcase
  endfunction

endpackage

// File: rtl/rxf_rst_sync.sv
module rxf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];

endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 11,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             clr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] head
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, wp_d;
  logic [AW-1:0]    rp_q, rp_d;

  // entry storage, no reset needed
  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= wdata;
  end

  // pointer next state
  always_comb begin
    wp_d = wp_q;
    rp_d = rp_q;
    if (clr) begin
      wp_d = '0;
      rp_d = '0;
    end else begin
      if (push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
      if (pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  assign head = mem[rp_q];

endmodule

// File: rtl/rxf_level.sv
module rxf_level #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          clr,
  input  logic          lost,
  input  logic          fifo_en,
  input  logic [CW-1:0] thr,
  output logic [CW-1:0] count,
  output logic          hit,
  output logic          ovr
);

  logic [CW-1:0] count_q, count_d;
  logic          hit_q, hit_d;
  logic          ovr_q, ovr_d;

  always_comb begin
    if (clr) count_d = '0;
    else     count_d = count_q + CW'(push) - CW'(pop);
  end

  // trigger flag with hysteresis: set at threshold, cleared at empty
  always_comb begin
    hit_d = hit_q;
    if (clr || !fifo_en)      hit_d = 1'b0;
    else if (count_d >= thr)  hit_d = 1'b1;
    else if (count_d == '0)   hit_d = 1'b0;
  end

  always_comb begin
    if (clr) ovr_d = 1'b0;
    else     ovr_d = ovr_q | lost;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      hit_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      hit_q   <= hit_d;
      ovr_q   <= ovr_d;
    end
  end

  assign count = count_q;
  assign hit   = hit_q;
  assign ovr   = ovr_q;

endmodule

// File: rtl/rxfifo_autorts.sv
module rxfifo_autorts
  import rxf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ERR_W-1:0]  wr_err,
  input  logic              rd_en,
  input  logic              fifo_en,
  input  logic              autorts_en,
  input  logic [1:0]        trig_sel,
  input  logic              flush,
  output logic [DATA_W-1:0] rd_data,
  output logic [ERR_W-1:0]  rd_err,
  output logic              empty,
  output logic              data_ready,
  output logic              rxrdy_n,
  output logic              rts_n,
  output logic              overrun
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = DATA_W + ERR_W;

  logic          rst_n_s;
  logic          mode_q;
  logic          clr;
  logic [CW-1:0] cap;
  logic [CW-1:0] thr;
  logic [CW-1:0] count;
  logic          full;
  logic          push, pop, lost;
  logic          hit, ovr;
  logic [EW-1:0] head;

  rxf_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  // last seen mode, to detect a mode change
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) mode_q <= 1'b0;
    else          mode_q <= fifo_en;
  end

  assign clr   = flush | (fifo_en != mode_q);
  assign cap   = fifo_en ? CW'(DEPTH) : CW'(1);
  assign thr   = CW'(trig_level(trig_sel, DEPTH));
  assign empty = (count == '0);
  assign full  = (count == cap);
  assign pop   = rd_en & ~empty & ~clr;
  assign push  = wr_en & ~clr & (~full | pop);
  assign lost  = wr_en & ~clr & full & ~pop;

  rxf_store #(.DEPTH(DEPTH), .WIDTH(EW)) u_store (
    .clk   (clk),
    .rst_n (rst_n_s),
    .push  (push),
    .pop   (pop),
    .clr   (clr),
    .wdata ({wr_err, wr_data}),
    .head  (head)
  );

  rxf_level #(.DEPTH(DEPTH)) u_level (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .push    (push),
    .pop     (pop),
    .clr     (clr),
    .lost    (lost),
    .fifo_en (fifo_en),
    .thr     (thr),
    .count   (count),
    .hit     (hit),
    .ovr     (ovr)
  );

  assign rd_data    = empty ? '0 : head[DATA_W-1:0];
  assign rd_err     = empty ? '0 : head[EW-1:DATA_W];
  assign data_ready = ~empty;
  assign rxrdy_n    = fifo_en ? ~hit : empty;
  assign rts_n      = fifo_en & autorts_en & hit;
  assign overrun    = ovr;

endmodule

// File: rtl/rxfifo_autorts_chk.sv
module rxfifo_autorts_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n_s,
  input logic          wr_en,
  input logic          rd_en,
  input logic          flush,
  input logic          fifo_en,
  input logic          clr,
  input logic          full,
  input logic          empty,
  input logic          rts_n,
  input logic          rxrdy_n,
  input logic          overrun,
  input logic [CW-1:0] count
);

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n_s)
    count <= CW'(DEPTH)); // R1

  AST_HOLD_CAP: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!fifo_en && !clr) |-> (count <= CW'(1))); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && full && !rd_en && !clr) |=> (overrun && count == $past(count))); // R4

  AST_RW_FULL: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && rd_en && full && !clr) |=> (count == $past(count) && overrun == $past(overrun))); // R5

  AST_RTS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n_s)
    empty |-> !rts_n); // R6

  AST_RXRDY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n_s)
    empty |-> rxrdy_n); // R8

  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n_s)
    flush |=> (empty && !overrun)); // R9

endmodule

bind rxfifo_autorts rxfifo_autorts_chk #(.DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .rst_n_s (rst_n_s),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .flush   (flush),
  .fifo_en (fifo_en),
  .clr     (clr),
  .full    (full),
  .empty   (empty),
  .rts_n   (rts_n),
  .rxrdy_n (rxrdy_n),
  .overrun (overrun),
  .count   (count)
);

// File: tb/rxfifo_autorts_test.sv
module rxfifo_autorts_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en, fifo_en, autorts_en, flush;
  logic [7:0] wr_data;
  logic [2:0] wr_err;
  logic [1:0] trig_sel;
  logic [7:0] rd_data;
  logic [2:0] rd_err;
  logic       empty, data_ready, rxrdy_n, rts_n, overrun;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rxfifo_autorts uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_err(wr_err),
    .rd_en(rd_en), .fifo_en(fifo_en), .autorts_en(autorts_en), .trig_sel(trig_sel),
    .flush(flush), .rd_data(rd_data), .rd_err(rd_err), .empty(empty),
    .data_ready(data_ready), .rxrdy_n(rxrdy_n), .rts_n(rts_n), .overrun(overrun)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one clock of stimulus; returns 1 ns after the edge
  task automatic step(input logic w, input logic [7:0] d, input logic [2:0] e,
                      input logic r, input logic f);
    wr_en = w; wr_data = d; wr_err = e; rd_en = r; flush = f;
    @(posedge clk);
    #1;
    wr_en = 1'b0; rd_en = 1'b0; flush = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d, input logic [2:0] e);
    step(1'b1, d, e, 1'b0, 1'b0);
  endtask

  task automatic rd();
    step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
  endtask

  task automatic idle();
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    chk("R2", "empty", 32'(empty), 32'd1);
    chk("R11", "data_ready", 32'(data_ready), 32'd0);
    chk("R2", "rxrdy_n", 32'(rxrdy_n), 32'd1);
    chk("R2", "rts_n", 32'(rts_n), 32'd0);
    chk("R2", "overrun", 32'(overrun), 32'd0);
    chk("R11", "rd_data empty", 32'(rd_data), 32'd0);
    chk("R11", "rd_err empty", 32'(rd_err), 32'd0);
  endtask

  task automatic t_holding();
    wr(8'hA5, 3'b001);
    chk("R11", "data_ready", 32'(data_ready), 32'd1);
    chk("R8", "rxrdy_n held", 32'(rxrdy_n), 32'd0);
    chk("R3", "rd_data", 32'(rd_data), 32'hA5);
    chk("R1", "rd_err parity", 32'(rd_err), 32'b001);
    wr(8'h5A, 3'b000);
    chk("R3", "overrun", 32'(overrun), 32'd1);
    chk("R3", "held kept", 32'(rd_data), 32'hA5);
    rd();
    chk("R3", "empty after read", 32'(empty), 32'd1);
    chk("R8", "rxrdy_n empty", 32'(rxrdy_n), 32'd1);
  endtask

  task automatic t_mode_on();
    fifo_en = 1'b1;
    wr(8'h33, 3'b000);
    chk("R10", "overrun cleared", 32'(overrun), 32'd0);
    chk("R10", "write dropped", 32'(empty), 32'd1);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 16; i++) wr(8'h10 + 8'(i), 3'(i));
    chk("R4", "no overrun at 16", 32'(overrun), 32'd0);
    wr(8'hEE, 3'b111);
    chk("R4", "overrun", 32'(overrun), 32'd1);
    chk("R4", "head kept", 32'(rd_data), 32'h10);
    for (int i = 0; i < 16; i++) begin
      chk("R1", "order", 32'(rd_data), 32'h10 + 32'(i));
      chk("R1", "err tags", 32'(rd_err), 32'(i % 8));
      rd();
    end
    chk("R1", "empty after drain", 32'(empty), 32'd1);
    rd();
    chk("R5", "read on empty", 32'(empty), 32'd1);
    wr(8'h77, 3'b010);
    chk("R5", "pointer unmoved", 32'(rd_data), 32'h77);
    chk("R1", "rd_err framing", 32'(rd_err), 32'b010);
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
    chk("R9", "flush empty", 32'(empty), 32'd1);
    chk("R9", "flush overrun", 32'(overrun), 32'd0);
  endtask

  task automatic t_rw_full();
    for (int i = 0; i < 16; i++) wr(8'h40 + 8'(i), 3'b000);
    step(1'b1, 8'hCC, 3'b100, 1'b1, 1'b0);
    chk("R5", "no overrun", 32'(overrun), 32'd0);
    chk("R5", "head advanced", 32'(rd_data), 32'h41);
    for (int i = 0; i < 15; i++) rd();
    chk("R5", "new last", 32'(rd_data), 32'hCC);
    chk("R1", "rd_err break", 32'(rd_err), 32'b100);
    rd();
    chk("R5", "empty after 16", 32'(empty), 32'd1);
  endtask

  task automatic t_rts();
    int lvl [4] = '{1, 4, 8, 14};
    autorts_en = 1'b1;
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      for (int k = 0; k < lvl[s] - 1; k++) wr(8'(k), 3'b000);
      chk("R6", "rts below level", 32'(rts_n), 32'd0);
      chk("R8", "rxrdy below level", 32'(rxrdy_n), 32'd1);
      wr(8'hF0, 3'b000);
      chk("R6", "rts at level", 32'(rts_n), 32'd1);
      chk("R8", "rxrdy at level", 32'(rxrdy_n), 32'd0);
      for (int k = 0; k < lvl[s] - 1; k++) rd();
      chk("R6", "rts held", 32'(rts_n), 32'd1);
      rd();
      chk("R6", "rts empty", 32'(rts_n), 32'd0);
      chk("R8", "rxrdy empty", 32'(rxrdy_n), 32'd1);
    end
  endtask

  task automatic t_rts_off();
    autorts_en = 1'b0;
    trig_sel = 2'd3;
    for (int k = 0; k < 14; k++) wr(8'(k), 3'b000);
    chk("R7", "rts off auto", 32'(rts_n), 32'd0);
    chk("R8", "rxrdy at level", 32'(rxrdy_n), 32'd0);
    autorts_en = 1'b1;
    fifo_en = 1'b0;
    #1;
    chk("R7", "rts off fifo", 32'(rts_n), 32'd0);
    idle();
    chk("R10", "mode change empties", 32'(empty), 32'd1);
    wr(8'h21, 3'b000);
    chk("R3", "holding write", 32'(rd_data), 32'h21);
    fifo_en = 1'b1;
    idle();
    chk("R10", "mode change empties", 32'(empty), 32'd1);
  endtask

  task automatic t_flush();
    autorts_en = 1'b1;
    trig_sel = 2'd2;
    for (int k = 0; k < 17; k++) wr(8'h60 + 8'(k), 3'b000);
    chk("R4", "overrun", 32'(overrun), 32'd1);
    chk("R6", "rts full", 32'(rts_n), 32'd1);
    step(1'b1, 8'h99, 3'b000, 1'b0, 1'b1);
    chk("R9", "empty", 32'(empty), 32'd1);
    chk("R9", "overrun", 32'(overrun), 32'd0);
    chk("R9", "rts low", 32'(rts_n), 32'd0);
    for (int k = 0; k < 8; k++) wr(8'hB0 + 8'(k), 3'b000);
    chk("R9", "rts again", 32'(rts_n), 32'd1);
    chk("R9", "write dropped", 32'(rd_data), 32'hB0);
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; flush = 1'b0;
    wr_data = '0; wr_err = '0;
    fifo_en = 1'b0; autorts_en = 1'b0; trig_sel = 2'd0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_holding();
    t_mode_on();
    t_fill();
    t_rw_full();
    t_rts();
    t_rts_off();
    t_flush();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule